// File: doc/BRIEF.md
# Dual GPIO Port with Mismatch Detection

This block provides a pair of 8-bit general-purpose I/O ports for a small processor register bus. Each port has a data latch, a digital/analog selection register and a drive-style register that picks push-pull or open-drain. The pad is modelled as separate output value, output enable, pull-up enable and sampled input signals, so no tri-state buffer is needed. All pin inputs are first synchronized by two flip-flops.

Each port also holds a mask and a compare pattern. The block raises a level event whenever, on any port, the masked synchronized pins differ from the masked pattern. The event always produces a wake request for a clock controller. It produces an interrupt request only while the interrupt enable bit is set. The comparison uses the raw synchronized pins, whatever the pin modes are.

Top module: `gpm_port_pair`

## Requirements
- R1: After reset, every latch and every digital-select register reads as 0xFF. The drive-style, mask, pattern and control registers read as 0x00. No pad is driven (pad_oe all 0), every pull-up is on, and match_evt, irq and wake are 0.
- R2: For port p, a mismatch exists when ((pins AND mask) XOR (pattern AND mask)) is nonzero. Port p's pins are pad_in[8p+7:8p]. match_evt is 1 exactly when a mismatch exists on a port.
- R3: match_evt is the OR of the mismatch conditions of both ports.
- R4: irq equals match_evt AND the interrupt enable (control bit 0).
- R5: wake equals match_evt, whatever the interrupt enable is set to.
- R6: pad_out carries the latch bit. A digital pin is driven (pad_oe=1) when its latch is 0, or when its drive-style bit is 1 (push-pull). A digital pin with latch 1 and drive-style 0 is released.
- R7: Reading a port's pin address (offset 0) returns the synchronized pin level ANDed with the digital-select register, so analog pins (select bit 0) read as 0.
- R8: An analog pin never has pad_oe or pad_pu set.
- R9: pad_pu is 1 only on digital pins that are open-drain with latch 1. Control bit 1 set to 1 forces every pad_pu to 0. pad_pu and pad_oe are never both 1 on the same pin.
- R10: A pin change on pad_in first reaches match_evt after exactly two rising clock edges.
- R11: Address map: port p registers sit at 8p plus an offset, where 0 is the latch (write) or pin level (read), 1 is digital-select, 2 is drive-style, 3 is mask and 4 is pattern. The control register is at address 31. Read data appears on bus_rdata after the edge that samples bus_rd and then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 16 | Raw pin levels, port 1 in the upper byte |
| pad_out | output | 16 | Pin drive value |
| pad_oe | output | 16 | Pin drive enable |
| pad_pu | output | 16 | Weak pull-up enable |
| match_evt | output | 1 | Mismatch event on either port |
| irq | output | 1 | Gated interrupt request |
| wake | output | 1 | Wake request for a suspended clock |

## Verification
On every cycle, the assertions check that irq never appears without the event, that wake tracks the event, that analog pins are neither driven nor pulled up, that pull-up and drive never coincide, that the global pull-up disable holds, and that read data holds between reads. The masked comparison for each pattern, the OR across the two ports, the exact two-edge latency, the reset values and the readback of analog pins as zero depend on particular stimulus. Only the bench's vector table and its directed scenarios can show those.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
  localparam int OFF_PIN     = 0;
  localparam int OFF_DIGSEL  = 1;
  localparam int OFF_DRIVE   = 2;
  localparam int OFF_MASK    = 3;
  localparam int OFF_PATTERN = 4;
  localparam int CTRL_IE_BIT   = 0;
  localparam int CTRL_WPUD_BIT = 1;
  typedef logic [2:0] reg_off_t;
endpackage

// File: rtl/gpm_sync.sv
module gpm_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpm_port.sv
module gpm_port
  import gpm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  reg_off_t     off,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_s,
  input  logic         wpu_dis,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] rd_val,
  output logic [W-1:0] digsel,
  output logic         mismatch
);
  logic [W-1:0] latch_q, drive_q, mask_q, pattern_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q   <= '1;
      digsel    <= '1;
      drive_q   <= '0;
      mask_q    <= '0;
      pattern_q <= '0;
    end else if (we) begin
      case (off)
        reg_off_t'(OFF_PIN):     latch_q   <= wdata;
        reg_off_t'(OFF_DIGSEL):  digsel    <= wdata;
        reg_off_t'(OFF_DRIVE):   drive_q   <= wdata;
        reg_off_t'(OFF_MASK):    mask_q    <= wdata;
        reg_off_t'(OFF_PATTERN): pattern_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    pad_out  = latch_q;
    pad_oe   = digsel & (~latch_q | drive_q);
    pad_pu   = digsel & ~drive_q & latch_q & {W{~wpu_dis}};
    mismatch = |((pin_s ^ pattern_q) & mask_q);
    case (off)
      reg_off_t'(OFF_PIN):     rd_val = pin_s & digsel;
      reg_off_t'(OFF_DIGSEL):  rd_val = digsel;
      reg_off_t'(OFF_DRIVE):   rd_val = drive_q;
      reg_off_t'(OFF_MASK):    rd_val = mask_q;
      reg_off_t'(OFF_PATTERN): rd_val = pattern_q;
      default:                 rd_val = '0;
    endcase
  end
endmodule

// File: rtl/gpm_port_pair.sv
module gpm_port_pair
  import gpm_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [PORT_W-1:0]           bus_wdata,
  output logic [PORT_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
  output logic [NUM_PORTS*PORT_W-1:0] pad_out,
  output logic [NUM_PORTS*PORT_W-1:0] pad_oe,
  output logic [NUM_PORTS*PORT_W-1:0] pad_pu,
  output logic                        match_evt,
  output logic                        irq,
  output logic                        wake
);
  localparam int TOTAL_W = NUM_PORTS * PORT_W;
  localparam int IDX_W   = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

  logic [TOTAL_W-1:0]  pin_s;
  logic [TOTAL_W-1:0]  digsel_all;
  logic [NUM_PORTS-1:0] mismatch_v;
  logic [PORT_W-1:0]   rd_vals [NUM_PORTS];
  logic                ctrl_ie, wpu_dis;
  logic                ctrl_we;
  logic [PORT_W-1:0]   rd_next;
  logic                addr_is_ctrl;

  gpm_sync #(.W(TOTAL_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s)
  );

  assign addr_is_ctrl = (bus_addr == CTRL_ADDR);
  assign ctrl_we      = bus_wr && addr_is_ctrl;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic sel;
    assign sel = !addr_is_ctrl && (bus_addr[ADDR_W-1:3] == IDX_W'(p));
    gpm_port #(.W(PORT_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bus_wr && sel),
      .off      (bus_addr[2:0]),
      .wdata    (bus_wdata),
      .pin_s    (pin_s[p*PORT_W +: PORT_W]),
      .wpu_dis  (wpu_dis),
      .pad_out  (pad_out[p*PORT_W +: PORT_W]),
      .pad_oe   (pad_oe[p*PORT_W +: PORT_W]),
      .pad_pu   (pad_pu[p*PORT_W +: PORT_W]),
      .rd_val   (rd_vals[p]),
      .digsel   (digsel_all[p*PORT_W +: PORT_W]),
      .mismatch (mismatch_v[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_ie <= 1'b0;
      wpu_dis <= 1'b0;
    end else if (ctrl_we) begin
      ctrl_ie <= bus_wdata[CTRL_IE_BIT];
      wpu_dis <= bus_wdata[CTRL_WPUD_BIT];
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr_is_ctrl) begin
      rd_next[CTRL_IE_BIT]   = ctrl_ie;
      rd_next[CTRL_WPUD_BIT] = wpu_dis;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (bus_addr[ADDR_W-1:3] == IDX_W'(p)) rd_next = rd_vals[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign match_evt = |mismatch_v;
  assign wake      = match_evt;
  assign irq       = match_evt & ctrl_ie;
endmodule

// File: rtl/gpm_checker.sv
module gpm_checker #(
  parameter int N  = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic [DW-1:0] bus_rdata,
  input logic [N-1:0]  pad_oe,
  input logic [N-1:0]  pad_pu,
  input logic [N-1:0]  digsel,
  input logic          wpu_dis,
  input logic          match_evt,
  input logic          irq,
  input logic          wake
);
  AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> match_evt); // R4
  AST_WAKE_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |-> wake); // R5
  AST_ANALOG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((~digsel) & (pad_oe | pad_pu)) == '0); // R8
  AST_PU_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0); // R9
  AST_PU_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    wpu_dis |-> (pad_pu == '0)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

bind gpm_port_pair gpm_checker #(.N(NUM_PORTS*PORT_W), .DW(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pad_oe(pad_oe), .pad_pu(pad_pu), .digsel(digsel_all), .wpu_dis(wpu_dis),
  .match_evt(match_evt), .irq(irq), .wake(wake)
);

// File: tb/sim_gpm_port_pair.sv
module sim_gpm_port_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe, pad_pu;
  logic        match_evt, irq, wake;
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gpm_port_pair u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .match_evt(match_evt), .irq(irq), .wake(wake)
  );

  // {pins, mask, pattern, expected event}
  localparam logic [24:0] VEC [7] = '{
    {8'hA5, 8'h00, 8'hFF, 1'b0},
    {8'hA5, 8'hFF, 8'hA5, 1'b0},
    {8'hA5, 8'hFF, 8'hA4, 1'b1},
    {8'hA5, 8'hF0, 8'hAF, 1'b0},
    {8'hA5, 8'h0F, 8'h55, 1'b0},
    {8'h3C, 8'h81, 8'h00, 1'b0},
    {8'h3C, 8'h04, 8'h00, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", 32'(pad_oe), 32'h0000);
    chk("R1 pu", 32'(pad_pu), 32'hFFFF);
    chk("R1 out", 32'(pad_out), 32'hFFFF);
    chk("R1 evt/irq/wake", {29'd0, match_evt, irq, wake}, 32'd0);
    rd(5'd1, d);  chk("R1 digsel0", 32'(d), 32'hFF);
    rd(5'd9, d);  chk("R1 digsel1", 32'(d), 32'hFF);
    rd(5'd2, d);  chk("R1 drive0", 32'(d), 32'h00);
    rd(5'd3, d);  chk("R1 mask0", 32'(d), 32'h00);
    rd(5'd12, d); chk("R1 pattern1", 32'(d), 32'h00);
    rd(5'd31, d); chk("R1 ctrl", 32'(d), 32'h00);

    // R2 / R5 vector table on port 0
    for (int i = 0; i < 7; i++) begin
      wr(5'd3, VEC[i][16:9]);
      wr(5'd4, VEC[i][8:1]);
      pad_in[7:0] = VEC[i][24:17];
      settle();
      chk("R2 evt", 32'(match_evt), 32'(VEC[i][0]));
      chk("R5 wake", 32'(wake), 32'(VEC[i][0]));
    end

    // R10 latency
    wr(5'd3, 8'hFF);
    wr(5'd4, 8'h00);
    pad_in[7:0] = 8'h00;
    settle();
    chk("R10 idle", 32'(match_evt), 32'd0);
    pad_in[7:0] = 8'h01;
    @(negedge clk);
    chk("R10 after one edge", 32'(match_evt), 32'd0);
    @(negedge clk);
    chk("R10 after two edges", 32'(match_evt), 32'd1);

    // R4 interrupt gating, R5 wake independent
    chk("R4 irq off", 32'(irq), 32'd0);
    chk("R5 wake w/o ie", 32'(wake), 32'd1);
    wr(5'd31, 8'h01);
    @(negedge clk);
    chk("R4 irq on", 32'(irq), 32'd1);
    wr(5'd31, 8'h00);
    @(negedge clk);
    chk("R4 irq off again", 32'(irq), 32'd0);

    // R3 OR across ports
    pad_in[7:0] = 8'h00;
    settle();
    chk("R3 port0 clear", 32'(match_evt), 32'd0);
    wr(5'd11, 8'hFF);
    wr(5'd12, 8'h00);
    pad_in[15:8] = 8'h80;
    settle();
    chk("R3 port1 event", 32'(match_evt), 32'd1);
    pad_in[15:8] = 8'h00;
    settle();
    chk("R3 port1 clear", 32'(match_evt), 32'd0);

    // R7 digital readback
    pad_in[7:0] = 8'hA5;
    settle();
    rd(5'd0, d); chk("R7 pins", 32'(d), 32'hA5);
    rd(5'd16, d); chk("R11 unmapped port", 32'(d), 32'h00);

    // R6 / R9 drive and pull-up
    wr(5'd0, 8'h0F);
    wr(5'd2, 8'h03);
    @(negedge clk);
    chk("R6 out", 32'(pad_out[7:0]), 32'h0F);
    chk("R6 oe", 32'(pad_oe), 32'h00F3);
    chk("R9 pu", 32'(pad_pu), 32'hFF0C);
    wr(5'd31, 8'h02);
    @(negedge clk);
    chk("R9 global off", 32'(pad_pu), 32'h0000);
    wr(5'd31, 8'h00);

    // R8 / R7 analog pins
    wr(5'd1, 8'hF0);
    @(negedge clk);
    chk("R8 oe", 32'(pad_oe), 32'h00F0);
    chk("R8 pu", 32'(pad_pu), 32'hFF00);
    pad_in[7:0] = 8'hFF;
    settle();
    rd(5'd0, d); chk("R7 analog zero", 32'(d), 32'hF0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule